// File: doc/BRIEF.md
# Pulse-Swallow Divider Control

This block is the digital counter chain that follows a dual-modulus prescaler in a PLL feedback path. It is clocked by the prescaler output. Each full divide cycle lasts M+1 prescaler output periods. During the first A of those periods it drives a modulus-control line high, which makes the prescaler divide by P+1. For the rest of the cycle the line is low and the prescaler divides by P. The total division from the VCO to the output pulse is therefore P*(M+1)+A. The low modulus P is 5 when the 5/6 pair is selected and 10 when the 10/11 pair is selected.

The M value, the A value and the pair select are captured into shadow registers at the first period of each cycle. A change made part-way through a cycle only takes effect at the next cycle boundary. The pair select is passed to the prescaler through the same shadow, so it changes at that boundary too. A combinational flag reports whether the settings now on the inputs would give a wrong divide sequence.

Top module: `swallow_div_ctl`

## Requirements
- R1: While reset is asserted, and up to the first configuration load after reset is released, `mod_ctl` and `fp_pulse` are both 0. Asserting reset forces both to 0 at once.
- R2: For a valid setting, one full cycle spans P*(M+1)+A VCO periods. P is 5 when `pair_sel_in`=0 and 10 when `pair_sel_in`=1. A may be any value from 0 to 15.
- R3: `mod_ctl` is high for exactly A prescaler-output periods in each cycle. Those periods are the first A periods of the cycle.
- R4: `fp_pulse` is high for exactly one prescaler-output period per cycle. That period is the last one, in which the period counter equals M.
- R5: `cfg_invalid` is 1 exactly when `m_val`=0 or `a_val` > `m_val`+1, judged on the live input values. Otherwise it is 0.
- R6: Changes to `m_val`, `a_val` or `pair_sel_in` during a cycle do not alter that cycle's length or its `mod_ctl` count. They take effect from the next cycle. `pair_sel` follows `pair_sel_in` only at a cycle boundary.
- R7: The minimum valid setting, M=1, gives a cycle of two prescaler-output periods, so the total division is 2P+A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pre_clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_val | input | MW | Programmed M value; a cycle lasts M+1 periods |
| a_val | input | AW | Programmed A value; number of P+1 periods per cycle |
| pair_sel_in | input | 1 | Prescaler pair request: 0 = 5/6, 1 = 10/11 |
| mod_ctl | output | 1 | Modulus control to the prescaler; 1 selects P+1 |
| pair_sel | output | 1 | Shadowed pair select driven to the prescaler |
| fp_pulse | output | 1 | Divided output pulse, one period wide per cycle |
| cfg_invalid | output | 1 | Live inputs give an invalid divide sequence |

## Verification
Suppose the period counter or a shadow register held a wrong value. Within one divide cycle, the VCO-period count between cycle boundaries would no longer match P*(M+1)+A. The count of `mod_ctl` periods would also move away from A. If the shadow were loaded at the wrong moment, a configuration change made mid-cycle would alter the cycle in progress. That would show on the first boundary after the change rather than the second. A stuck `fp_pulse` would show up in the per-cycle pulse count, or as a cycle boundary that never arrives.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // Prescaler pair encoding driven on pair_sel
  typedef enum logic {
    PAIR_LO = 1'b0,   // 5/6 pair
    PAIR_HI = 1'b1    // 10/11 pair
  } pair_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sdc_rst_sync.sv
module sdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/sdc_shadow.sv
module sdc_shadow #(
  parameter int unsigned MW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_b,
  input  logic          ld,
  input  logic [MW-1:0] m_in,
  input  logic [AW-1:0] a_in,
  input  logic          sel_in,
  output logic [MW-1:0] m_sh,
  output logic [AW-1:0] a_sh,
  output logic          sel_sh,
  output logic          armed
);
  logic [MW-1:0] m_d;
  logic [AW-1:0] a_d;
  logic          sel_d;
  logic          armed_d;

  always_comb begin
    m_d     = m_sh;
    a_d     = a_sh;
    sel_d   = sel_sh;
    armed_d = 1'b1;
    if (ld) begin
      m_d   = m_in;
      a_d   = a_in;
      sel_d = sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) begin
      m_sh   <= '0;
      a_sh   <= '0;
      sel_sh <= sdc_pkg::PAIR_LO;
      armed  <= 1'b0;
    end else begin
      m_sh   <= m_d;
      a_sh   <= a_d;
      sel_sh <= sel_d;
      armed  <= armed_d;
    end
  end

  // R1: the shadow arms on the first edge after reset release
  a_r1_arm_once: assert property (@(posedge clk) disable iff (!rst_b)
    armed |=> armed);
endmodule

// File: rtl/sdc_count.sv
module sdc_count #(
  parameter int unsigned MW = 8
) (
  input  logic          clk,
  input  logic          rst_b,
  input  logic          armed,
  input  logic [MW-1:0] m_sh,
  output logic [MW-1:0] cnt,
  output logic          ld
);
  logic [MW-1:0] cnt_d;

  always_comb begin
    ld    = !armed || (cnt >= m_sh);
    cnt_d = ld ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R4: the period counter never passes the shadowed terminal count
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_b)
    armed |-> (cnt <= m_sh));
endmodule

// File: rtl/sdc_decode.sv
module sdc_decode #(
  parameter int unsigned MW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_b,
  input  logic          armed,
  input  logic [MW-1:0] cnt,
  input  logic [MW-1:0] m_sh,
  input  logic [AW-1:0] a_sh,
  output logic          mod_ctl,
  output logic          fp
);
  localparam int unsigned XW = (MW > AW) ? MW : AW;

  logic [XW-1:0] cnt_x;
  logic [XW-1:0] a_x;

  always_comb begin
    cnt_x   = XW'(cnt);
    a_x     = XW'(a_sh);
    mod_ctl = armed && (cnt_x < a_x);
    fp      = armed && (cnt == m_sh);
  end

  // R3: modulus control is high only in a leading run of the cycle
  a_r3_mc_leading: assert property (@(posedge clk) disable iff (!rst_b)
    (mod_ctl && cnt != '0) |-> $past(mod_ctl));

  // R4: back-to-back pulses only when the cycle is one period long
  a_r4_fp_single: assert property (@(posedge clk) disable iff (!rst_b)
    (fp && $past(fp)) |-> (m_sh == '0));
endmodule

// File: rtl/sdc_cfg_check.sv
module sdc_cfg_check #(
  parameter int unsigned MW = 8,
  parameter int unsigned AW = 4
) (
  input  logic [MW-1:0] m_in,
  input  logic [AW-1:0] a_in,
  output logic          bad
);
  localparam int unsigned XW = ((MW > AW) ? MW : AW) + 1;

  logic [XW-1:0] m_x;
  logic [XW-1:0] a_x;

  always_comb begin
    m_x = XW'(m_in);
    a_x = XW'(a_in);
    bad = (m_in == '0) || (a_x > (m_x + 1'b1));
  end
endmodule

// File: rtl/swallow_div_ctl.sv
module swallow_div_ctl #(
  parameter int unsigned MW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          pre_clk,
  input  logic          rst_n,
  input  logic [MW-1:0] m_val,
  input  logic [AW-1:0] a_val,
  input  logic          pair_sel_in,
  output logic          mod_ctl,
  output logic          pair_sel,
  output logic          fp_pulse,
  output logic          cfg_invalid
);
  logic          rst_q;
  logic          armed;
  logic          ld;
  logic [MW-1:0] cnt;
  logic [MW-1:0] m_sh;
  logic [AW-1:0] a_sh;

  sdc_rst_sync #(.STAGES(sdc_pkg::SYNC_STAGES)) u_rst (
    .clk(pre_clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  sdc_shadow #(.MW(MW), .AW(AW)) u_shadow (
    .clk(pre_clk), .rst_b(rst_q), .ld(ld),
    .m_in(m_val), .a_in(a_val), .sel_in(pair_sel_in),
    .m_sh(m_sh), .a_sh(a_sh), .sel_sh(pair_sel), .armed(armed)
  );

  sdc_count #(.MW(MW)) u_count (
    .clk(pre_clk), .rst_b(rst_q), .armed(armed),
    .m_sh(m_sh), .cnt(cnt), .ld(ld)
  );

  sdc_decode #(.MW(MW), .AW(AW)) u_decode (
    .clk(pre_clk), .rst_b(rst_q), .armed(armed),
    .cnt(cnt), .m_sh(m_sh), .a_sh(a_sh),
    .mod_ctl(mod_ctl), .fp(fp_pulse)
  );

  sdc_cfg_check #(.MW(MW), .AW(AW)) u_check (
    .m_in(m_val), .a_in(a_val), .bad(cfg_invalid)
  );

  // R1: outputs stay quiet until the first configuration load
  a_r1_quiet_unarmed: assert property (@(posedge pre_clk) disable iff (!rst_q)
    !armed |-> (!mod_ctl && !fp_pulse));

  // R6: shadow state holds inside a cycle
  a_r6_hold_mid_cycle: assert property (@(posedge pre_clk) disable iff (!rst_q)
    (cnt != '0) |-> ($stable(m_sh) && $stable(a_sh) && $stable(pair_sel)));
endmodule

// File: tb/swallow_div_ctl_tb_top.sv
module swallow_div_ctl_tb_top;
  typedef struct packed {
    logic        sel;
    logic [7:0]  m;
    logic [3:0]  a;
    logic        inv;
    logic [15:0] n;
  } vec_t;

  // expected n = P*(M+1)+A, P=5 for sel 0, P=10 for sel 1
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd1,  4'd0,  1'b0, 16'd10},   // R7 minimum M
    '{1'b0, 8'd1,  4'd2,  1'b0, 16'd12},   // R7 with A = M+1
    '{1'b0, 8'd3,  4'd4,  1'b0, 16'd24},
    '{1'b0, 8'd8,  4'd0,  1'b0, 16'd45},
    '{1'b0, 8'd7,  4'd9,  1'b1, 16'd0},    // R5 A > M+1
    '{1'b0, 8'd7,  4'd8,  1'b0, 16'd48},
    '{1'b1, 8'd8,  4'd0,  1'b0, 16'd90},
    '{1'b1, 8'd8,  4'd9,  1'b0, 16'd99},
    '{1'b1, 8'd3,  4'd5,  1'b1, 16'd0},    // R5 A > M+1
    '{1'b1, 8'd15, 4'd15, 1'b0, 16'd175},  // R2 A at 15
    '{1'b0, 8'd0,  4'd0,  1'b1, 16'd0},    // R5 M zero
    '{1'b0, 8'd20, 4'd15, 1'b0, 16'd120},
    '{1'b1, 8'd3,  4'd4,  1'b0, 16'd44}
  };

  logic       vco = 1'b0;
  logic       pre_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] m_val = 8'd1;
  logic [3:0] a_val = 4'd0;
  logic       pair_sel_in = 1'b0;
  logic       mod_ctl, pair_sel, fp_pulse, cfg_invalid;

  int tests = 0;
  int fails = 0;

  swallow_div_ctl #(.MW(8), .AW(4)) dut_i (
    .pre_clk(pre_clk), .rst_n(rst_n), .m_val(m_val), .a_val(a_val),
    .pair_sel_in(pair_sel_in), .mod_ctl(mod_ctl), .pair_sel(pair_sel),
    .fp_pulse(fp_pulse), .cfg_invalid(cfg_invalid)
  );

  always #10 vco = ~vco;

  // behavioural prescaler: period of P or P+1 VCO cycles
  int pc = 0;
  int plen = 5;
  always @(posedge vco) begin
    if (pc >= plen - 1) begin pc <= 0; pre_clk <= 1'b1; end
    else begin pc <= pc + 1; pre_clk <= 1'b0; end
    if (pc == 1) plen <= (pair_sel ? 10 : 5) + (mod_ctl ? 1 : 0);
  end

  // cycle monitor: boundaries are falls of fp_pulse
  int vco_n = 0, t_fall = 0, fall_cnt = 0;
  int hi = 0, fpc = 0, last_len = 0, last_hi = 0, last_fp = 0;
  logic fp_d = 1'b0;
  always @(negedge vco) begin
    vco_n++;
    if (fp_d && !fp_pulse) begin
      last_len = vco_n - t_fall; t_fall = vco_n;
      last_hi = hi; last_fp = fpc; hi = 0; fpc = 0;
      fall_cnt++;
    end
    if (pc == 1) begin
      hi += int'(mod_ctl);
      fpc += int'(fp_pulse);
    end
    fp_d = fp_pulse;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    int s = fall_cnt;
    while (fall_cnt == s) @(posedge vco);
  endtask

  task automatic drive(input logic s, input logic [7:0] m, input logic [3:0] a);
    @(negedge vco);
    pair_sel_in = s; m_val = m; a_val = a;
    #1;
  endtask

  task automatic measure(input int n, input int a, input string tag);
    wait_fall();
    wait_fall();
    check({tag, " R2 cycle length"}, last_len, n);
    check({tag, " R3 mod_ctl periods"}, last_hi, a);
    check({tag, " R4 fp periods"}, last_fp, 1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (30) @(negedge vco);
    check("R1 mod_ctl in reset", int'(mod_ctl), 0);
    check("R1 fp in reset", int'(fp_pulse), 0);
    rst_n = 1'b1;
    #1;
    check("R1 mod_ctl after release", int'(mod_ctl), 0);
    check("R1 fp after release", int'(fp_pulse), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].sel, VECS[i].m, VECS[i].a);
      check($sformatf("R5 invalid flag vec %0d", i), int'(cfg_invalid), int'(VECS[i].inv));
      if (!VECS[i].inv) begin
        measure(int'(VECS[i].n), int'(VECS[i].a), $sformatf("vec %0d", i));
        check($sformatf("R6 pair_sel vec %0d", i), int'(pair_sel), int'(VECS[i].sel));
      end
    end

    // R6: mid-cycle change keeps the cycle in progress
    drive(1'b1, 8'd8, 4'd9);
    measure(99, 9, "R6 base");
    wait_fall();
    repeat (3) @(negedge vco);
    pair_sel_in = 1'b0; m_val = 8'd3; a_val = 4'd2;
    check("R6 pair_sel unchanged mid-cycle", int'(pair_sel), 1);
    wait_fall();
    check("R6 old cycle length", last_len, 99);
    check("R6 old mod_ctl count", last_hi, 9);
    wait_fall();
    check("R6 new cycle length", last_len, 22);
    check("R6 new mod_ctl count", last_hi, 2);

    // R1: reset during a high mod_ctl period
    while (!mod_ctl) @(negedge vco);
    rst_n = 1'b0;
    #1;
    check("R1 mod_ctl forced low", int'(mod_ctl), 0);
    check("R1 fp forced low", int'(fp_pulse), 0);
    repeat (20) @(negedge vco);
    rst_n = 1'b1;
    measure(22, 2, "R1 after re-reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule